// File: doc/BRIEF.md
# Integer ALU with Status Flags

This block is a purely combinational integer arithmetic and logic unit for operands of 8, 16, 32 or 64 bits. It carries out addition, addition with an incoming carry, subtraction, subtraction with an incoming borrow, compare, and the bitwise operations AND, OR, XOR and test. From the result it derives five status flags: carry, overflow, parity, sign and zero. It packs them into a flag word whose bit positions are fixed. The reserved and control positions of that word are kept and are driven to constant values.

A condition evaluator tests the freshly produced flags against a 4-bit condition code. It returns one taken bit, which a branch or select stage can use directly. The second operand comes either from a register input or from a 32-bit immediate. When the operation is 64 bits wide, the immediate is sign-extended. Compare and test produce flags only and keep the write-back enable low.

Top module: `flag_alu`

## Requirements
- R1: Operation code `op_i` selects 0=ADD, 1=ADC, 2=SUB, 3=SBB, 4=CMP, 5=AND, 6=OR, 7=XOR, 8=TEST. `width_i` selects 0=8, 1=16, 2=32, 3=64 bits. `result_o` holds the result at the active width, and every bit above that width is zero.
- R2: Carry (flag word bit 0) is set when an addition overflows as unsigned at the active width, or when a subtraction needs a borrow. ADC adds `carry_i`, and SBB subtracts `carry_i` as a borrow.
- R3: Parity (flag word bit 2) is set when the lowest byte of the result has an even number of one bits, whatever the width.
- R4: Zero (bit 6) is set when the result at the active width is all zeros. Sign (bit 7) equals the top bit of the result at the active width.
- R5: Overflow (bit 11) is set when an arithmetic result, taken as signed at the active width, cannot be represented.
- R6: AND, OR, XOR and TEST clear carry and overflow.
- R7: `wr_en_o` is high for ADD, ADC, SUB, SBB, AND, OR and XOR. It is low for CMP and TEST. CMP gives the same flags and result as SUB, and TEST gives the same as AND.
- R8: The flag word `flags_o` is 16 bits. Bit 1 reads as one. Only bits 0, 2, 6, 7 and 11 carry flags, and all other bits are zero.
- R9: Unsigned conditions: code 2 (below) = CF; 3 (above-or-equal) = !CF; 6 (below-or-equal) = CF|ZF; 7 (above) = !CF & !ZF.
- R10: Signed conditions: code 12 (less) = SF!=OF; 13 (greater-or-equal) = SF==OF; 14 (less-or-equal) = ZF | SF!=OF; 15 (greater) = !ZF & SF==OF.
- R11: Single-flag conditions: 0 = OF, 1 = !OF, 4 = ZF, 5 = !ZF, 8 = SF, 9 = !SF, 10 = PF, 11 = !PF.
- R12: With `use_imm_i` high, the second operand is `imm_i`. At 64-bit width it is sign-extended from bit 31. At narrower widths only its low bits are used.
- R13: Operation codes 9 to 15 give a zero result, a low `wr_en_o`, and a flag word with only bit 1 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand (register form) |
| imm_i | input | 32 | Immediate second operand |
| use_imm_i | input | 1 | Take the second operand from imm_i |
| op_i | input | 4 | Operation code |
| width_i | input | 2 | Operand width select |
| carry_i | input | 1 | Incoming carry/borrow for ADC and SBB |
| cond_i | input | 4 | Condition code to evaluate |
| result_o | output | 64 | Result, zero above the active width |
| wr_en_o | output | 1 | Result should be written back |
| flags_o | output | 16 | Packed flag word |
| taken_o | output | 1 | Condition met on the produced flags |

## Verification
Operands are drawn from boundary values, mixed with random words at every width. The boundary values are zero, all ones, the lone sign bit, the largest positive value and small numbers. They separate the unsigned carry from the signed overflow: for example, 0x7F+1 at 8 bits raises overflow but not carry, and 0xFF+1 raises carry but not overflow. The same operand pairs are tried at all four widths, with bits set above the active width. This exposes any flag or result taken from the wrong bit position. Condition codes are swept over flag states produced by compare and by signed and unsigned boundary pairs, so each of the sixteen conditions is seen both true and false. Immediate tests pair negative immediates with 32-bit and 64-bit widths, which distinguishes sign extension from truncation.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBB  = 4'd3,
    OP_CMP  = 4'd4,
    OP_AND  = 4'd5,
    OP_OR   = 4'd6,
    OP_XOR  = 4'd7,
    OP_TEST = 4'd8
  } alu_op_e;

  typedef enum logic [3:0] {
    CC_O  = 4'd0,  CC_NO = 4'd1,  CC_B  = 4'd2,  CC_AE = 4'd3,
    CC_E  = 4'd4,  CC_NE = 4'd5,  CC_BE = 4'd6,  CC_A  = 4'd7,
    CC_S  = 4'd8,  CC_NS = 4'd9,  CC_P  = 4'd10, CC_NP = 4'd11,
    CC_L  = 4'd12, CC_GE = 4'd13, CC_LE = 4'd14, CC_G  = 4'd15
  } cond_e;

  localparam int FLAG_W   = 16;
  localparam int FB_CARRY = 0;
  localparam int FB_ONE   = 1;
  localparam int FB_PAR   = 2;
  localparam int FB_ZERO  = 6;
  localparam int FB_SIGN  = 7;
  localparam int FB_OVF   = 11;

  typedef struct packed {
    logic cf;
    logic pf;
    logic zf;
    logic sf;
    logic of;
  } alu_flags_t;

endpackage

// File: rtl/flag_alu_operand.sv
module flag_alu_operand #(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 32,
  parameter int LANES  = 4,
  parameter int WSEL_W = 2
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              use_imm_i,
  input  logic [WSEL_W-1:0] width_i,
  output logic [DATA_W-1:0] a_o,
  output logic [DATA_W-1:0] b_o,
  output logic [WSEL_W-1:0] lane_o
);

  localparam int EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] mask_tab [LANES];
  logic [DATA_W-1:0] b_src;
  logic [DATA_W-1:0] mask_sel;

  for (genvar g = 0; g < LANES; g++) begin : g_mask
    localparam int LW = 8 << g;
    assign mask_tab[g] = {DATA_W{1'b1}} >> (DATA_W - LW);
  end

  // widths encoded past the widest lane fall back to the widest lane
  assign lane_o = (int'(width_i) >= LANES) ? WSEL_W'(LANES - 1) : width_i;

  // immediate is sign-extended to full width, then trimmed by the mask
  assign b_src = use_imm_i ? {{EXT_W{imm_i[IMM_W-1]}}, imm_i} : b_i;

  assign mask_sel = mask_tab[lane_o];
  assign a_o      = a_i   & mask_sel;
  assign b_o      = b_src & mask_sel;

endmodule

// File: rtl/flag_alu_core.sv
module flag_alu_core
  import flag_alu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LANES  = 4,
  parameter int WSEL_W = 2
) (
  input  logic [3:0]        op_i,
  input  logic [WSEL_W-1:0] lane_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] result_o,
  output alu_flags_t        flags_o,
  output logic              wr_en_o
);

  logic       valid;
  logic       is_arith;
  logic       is_sub;
  logic       cin_eff;
  logic [1:0] log_sel;
  logic       wr_en;

  // operation decode, shared by all width lanes
  always_comb begin
    valid    = 1'b1;
    is_arith = 1'b0;
    is_sub   = 1'b0;
    cin_eff  = 1'b0;
    log_sel  = 2'd0;
    wr_en    = 1'b1;
    case (op_i)
      OP_ADD:  is_arith = 1'b1;
      OP_ADC:  begin is_arith = 1'b1; cin_eff = carry_i; end
      OP_SUB:  begin is_arith = 1'b1; is_sub = 1'b1; cin_eff = 1'b1; end
      OP_SBB:  begin is_arith = 1'b1; is_sub = 1'b1; cin_eff = ~carry_i; end
      OP_CMP:  begin is_arith = 1'b1; is_sub = 1'b1; cin_eff = 1'b1; wr_en = 1'b0; end
      OP_AND:  log_sel = 2'd0;
      OP_OR:   log_sel = 2'd1;
      OP_XOR:  log_sel = 2'd2;
      OP_TEST: begin log_sel = 2'd0; wr_en = 1'b0; end
      default: begin valid = 1'b0; wr_en = 1'b0; end
    endcase
  end

  logic [DATA_W-1:0] lane_res [LANES];
  alu_flags_t        lane_fl  [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int LW = 8 << g;

    logic [LW-1:0] la;
    logic [LW-1:0] lb;
    logic [LW-1:0] binv;
    logic [LW-1:0] lsum;
    logic [LW-1:0] llog;
    logic [LW-1:0] lres;
    logic          lco;

    assign la   = a_i[LW-1:0];
    assign lb   = b_i[LW-1:0];
    assign binv = is_sub ? ~lb : lb;

    // subtraction runs as a + ~b + 1 (or + ~borrow); carry out inverted is the borrow
    assign {lco, lsum} = {1'b0, la} + {1'b0, binv} + {{LW{1'b0}}, cin_eff};

    always_comb begin
      case (log_sel)
        2'd0:    llog = la & lb;
        2'd1:    llog = la | lb;
        default: llog = la ^ lb;
      endcase
    end

    assign lres = !valid ? '0 : (is_arith ? lsum : llog);

    assign lane_res[g] = DATA_W'(lres);
    assign lane_fl[g]  = '{
      cf: valid & is_arith & (lco ^ is_sub),
      pf: valid & ~(^lres[7:0]),
      zf: valid & (lres == '0),
      sf: lres[LW-1],
      of: valid & is_arith & (la[LW-1] == binv[LW-1]) & (lsum[LW-1] != la[LW-1])
    };
  end

  assign result_o = lane_res[lane_i];
  assign flags_o  = lane_fl[lane_i];
  assign wr_en_o  = wr_en;

endmodule

// File: rtl/flag_alu_cond.sv
module flag_alu_cond
  import flag_alu_pkg::*;
(
  input  alu_flags_t flags_i,
  input  logic [3:0] cond_i,
  output logic       taken_o
);

  logic sign_ne_ovf;
  assign sign_ne_ovf = flags_i.sf ^ flags_i.of;

  always_comb begin
    case (cond_e'(cond_i))
      CC_O:    taken_o = flags_i.of;
      CC_NO:   taken_o = ~flags_i.of;
      CC_B:    taken_o = flags_i.cf;
      CC_AE:   taken_o = ~flags_i.cf;
      CC_E:    taken_o = flags_i.zf;
      CC_NE:   taken_o = ~flags_i.zf;
      CC_BE:   taken_o = flags_i.cf | flags_i.zf;
      CC_A:    taken_o = ~flags_i.cf & ~flags_i.zf;
      CC_S:    taken_o = flags_i.sf;
      CC_NS:   taken_o = ~flags_i.sf;
      CC_P:    taken_o = flags_i.pf;
      CC_NP:   taken_o = ~flags_i.pf;
      CC_L:    taken_o = sign_ne_ovf;
      CC_GE:   taken_o = ~sign_ne_ovf;
      CC_LE:   taken_o = flags_i.zf | sign_ne_ovf;
      default: taken_o = ~flags_i.zf & ~sign_ne_ovf;
    endcase
  end

endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter  int DATA_W = 64,
  parameter  int IMM_W  = 32,
  localparam int LANES  = $clog2(DATA_W / 8) + 1,
  localparam int WSEL_W = $clog2(LANES)
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              use_imm_i,
  input  logic [3:0]        op_i,
  input  logic [WSEL_W-1:0] width_i,
  input  logic              carry_i,
  input  logic [3:0]        cond_i,
  output logic [DATA_W-1:0] result_o,
  output logic              wr_en_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic              taken_o
);

  logic [DATA_W-1:0] a_m;
  logic [DATA_W-1:0] b_m;
  logic [WSEL_W-1:0] lane;
  alu_flags_t        fl;

  flag_alu_operand #(
    .DATA_W (DATA_W),
    .IMM_W  (IMM_W),
    .LANES  (LANES),
    .WSEL_W (WSEL_W)
  ) u_operand (
    .a_i       (a_i),
    .b_i       (b_i),
    .imm_i     (imm_i),
    .use_imm_i (use_imm_i),
    .width_i   (width_i),
    .a_o       (a_m),
    .b_o       (b_m),
    .lane_o    (lane)
  );

  flag_alu_core #(
    .DATA_W (DATA_W),
    .LANES  (LANES),
    .WSEL_W (WSEL_W)
  ) u_core (
    .op_i     (op_i),
    .lane_i   (lane),
    .a_i      (a_m),
    .b_i      (b_m),
    .carry_i  (carry_i),
    .result_o (result_o),
    .flags_o  (fl),
    .wr_en_o  (wr_en_o)
  );

  flag_alu_cond u_cond (
    .flags_i (fl),
    .cond_i  (cond_i),
    .taken_o (taken_o)
  );

  always_comb begin
    flags_o           = '0;
    flags_o[FB_ONE]   = 1'b1;
    flags_o[FB_CARRY] = fl.cf;
    flags_o[FB_PAR]   = fl.pf;
    flags_o[FB_ZERO]  = fl.zf;
    flags_o[FB_SIGN]  = fl.sf;
    flags_o[FB_OVF]   = fl.of;
  end

  // checks relating the core's outputs, the packed word and the evaluator
  int msb_idx;
  assign msb_idx = (8 << lane) - 1;

  always_comb begin
    if (op_i == OP_CMP || op_i == OP_TEST) begin
      p_flag_only_nowb_r7: assert (!wr_en_o);
    end
    if (wr_en_o) begin
      p_zero_matches_result_r4: assert (flags_o[FB_ZERO] == (result_o == '0));
      p_sign_matches_msb_r4:    assert (flags_o[FB_SIGN] == result_o[msb_idx]);
      p_parity_low_byte_r3:     assert (flags_o[FB_PAR] == ($countones(result_o[7:0]) % 2 == 0));
    end
    if (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR || op_i == OP_TEST) begin
      p_logic_clears_cv_r6: assert (!flags_o[FB_CARRY] && !flags_o[FB_OVF]);
    end
    if (cond_i == CC_E) begin
      p_equal_follows_zero_r11: assert (taken_o == flags_o[FB_ZERO]);
    end
    if (op_i > OP_TEST) begin
      p_undefined_is_inert_r13: assert (result_o == '0 && !wr_en_o);
    end
  end

endmodule

// File: tb/flag_alu_test.sv
module flag_alu_test;

  logic        clk = 1'b0;
  logic [63:0] a, b;
  logic [31:0] imm;
  logic        use_imm, cin;
  logic [3:0]  op, cond;
  logic [1:0]  width;
  logic [63:0] result;
  logic        wr_en, taken;
  logic [15:0] flags;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  flag_alu uut (
    .a_i(a), .b_i(b), .imm_i(imm), .use_imm_i(use_imm), .op_i(op),
    .width_i(width), .carry_i(cin), .cond_i(cond),
    .result_o(result), .wr_en_o(wr_en), .flags_o(flags), .taken_o(taken)
  );

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s op=%0d w=%0d cc=%0d actual=%h expected=%h",
               tag, what, op, width, cond, act, exp);
    end
  endtask

  function automatic logic [66:0] sext(input logic [63:0] v, input int bits);
    logic [66:0] t;
    t = {3'b000, v};
    for (int i = bits; i < 67; i++) t[i] = v[bits-1];
    return t;
  endfunction

  // behavioural model: wide arithmetic, range tests, bit counting
  task automatic model(output logic [63:0] res, output logic wb,
                       output logic [15:0] fw, output logic tk);
    int bits;
    logic [63:0] mask, bv, am, bm, r;
    logic [66:0] ua, ub, c, full;
    logic signed [66:0] sa, sb, sr, smax, smin;
    logic cf, of, pf, zf, sf, valid, arith;
    bits  = 8 << width;
    mask  = (bits == 64) ? '1 : ((64'd1 << bits) - 64'd1);
    bv    = use_imm ? {{32{imm[31]}}, imm} : b;
    am    = a & mask;
    bm    = bv & mask;
    ua    = {3'b000, am};
    ub    = {3'b000, bm};
    sa    = $signed(sext(am, bits));
    sb    = $signed(sext(bm, bits));
    smax  = (67'sd1 <<< (bits - 1)) - 67'sd1;
    smin  = -(67'sd1 <<< (bits - 1));
    cf = 0; of = 0; valid = 1; wb = 1; arith = 0; r = '0; sr = '0;
    case (op)
      4'd0, 4'd1: begin
        c = (op == 4'd1) ? {66'd0, cin} : 67'd0;
        full = ua + ub + c;
        cf = full > {3'b000, mask};
        sr = sa + sb + $signed(c);
        r = full[63:0]; arith = 1;
      end
      4'd2, 4'd3, 4'd4: begin
        c = (op == 4'd3) ? {66'd0, cin} : 67'd0;
        cf = ua < (ub + c);
        sr = sa - sb - $signed(c);
        r = am - bm - c[63:0]; arith = 1;
        wb = (op != 4'd4);
      end
      4'd5, 4'd8: begin r = am & bm; wb = (op != 4'd8); end
      4'd6: r = am | bm;
      4'd7: r = am ^ bm;
      default: begin valid = 0; wb = 0; end
    endcase
    if (arith) of = (sr > smax) || (sr < smin);
    res = r & mask;
    zf = valid && (res == '0);
    sf = valid && res[bits-1];
    pf = valid && ($countones(res[7:0]) % 2 == 0);
    fw = 16'h0002;
    fw[0] = cf; fw[2] = pf; fw[6] = zf; fw[7] = sf; fw[11] = of;
    case (cond)
      4'd0:  tk = of;          4'd1:  tk = !of;
      4'd2:  tk = cf;          4'd3:  tk = !cf;
      4'd4:  tk = zf;          4'd5:  tk = !zf;
      4'd6:  tk = cf || zf;    4'd7:  tk = !cf && !zf;
      4'd8:  tk = sf;          4'd9:  tk = !sf;
      4'd10: tk = pf;          4'd11: tk = !pf;
      4'd12: tk = sf != of;    4'd13: tk = sf == of;
      4'd14: tk = zf || (sf != of);
      default: tk = !zf && (sf == of);
    endcase
  endtask

  task automatic compare_all();
    logic [63:0] er; logic ew; logic [15:0] ef; logic et;
    string rt, ct, tt;
    bit is_log, is_undef;
    model(er, ew, ef, et);
    is_log   = (op >= 4'd5 && op <= 4'd8);
    is_undef = (op > 4'd8);
    rt = is_undef ? "R13" : (use_imm ? "R12" : "R1");
    ct = is_undef ? "R13" : (is_log ? "R6" : "R2");
    if (cond == 4'd2 || cond == 4'd3 || cond == 4'd6 || cond == 4'd7) tt = "R9";
    else if (cond >= 4'd12) tt = "R10";
    else tt = "R11";
    chk(rt, "result", result, er);
    chk("R7", "wr_en", {63'd0, wr_en}, {63'd0, ew});
    chk(ct, "carry", {63'd0, flags[0]}, {63'd0, ef[0]});
    chk(is_log ? "R6" : "R5", "overflow", {63'd0, flags[11]}, {63'd0, ef[11]});
    chk("R3", "parity", {63'd0, flags[2]}, {63'd0, ef[2]});
    chk("R4", "zero/sign", {62'd0, flags[7], flags[6]}, {62'd0, ef[7], ef[6]});
    chk(is_undef ? "R13" : "R8", "flagword", {48'd0, flags}, {48'd0, ef});
    chk(tt, "taken", {63'd0, taken}, {63'd0, et});
  endtask

  function automatic logic [63:0] pick();
    case ($urandom % 7)
      0: return 64'd0;
      1: return '1;
      2: return 64'd1 << (8 << ($urandom % 4)) - 1;
      3: return (64'd1 << ((8 << ($urandom % 4)) - 1)) - 64'd1;
      4: return 64'($urandom % 4);
      default: return {$urandom, $urandom};
    endcase
  endfunction

  task automatic apply(input logic [3:0] o, input logic [1:0] w,
                       input logic [63:0] x, input logic [63:0] y,
                       input logic [31:0] im, input logic ui,
                       input logic ci, input logic [3:0] cc);
    @(posedge clk);
    op = o; width = w; a = x; b = y; imm = im; use_imm = ui; cin = ci; cond = cc;
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    op = 0; width = 0; a = 0; b = 0; imm = 0; use_imm = 0; cin = 0; cond = 0;
    @(negedge clk);
    // idle inputs: 0+0 at 8 bits gives zero and even parity, R8 word 0x0046
    chk("R8", "idle flagword", {48'd0, flags}, 64'h0046);
    chk("R1", "idle result", result, 64'd0);

    // R5: 0x7F+1 at 8 bits: overflow and sign, no carry -> word 0x0882
    apply(4'd0, 2'd0, 64'h7F, 64'h1, 0, 0, 0, 4'd0);
    chk("R5", "7F+1 word", {48'd0, flags}, 64'h0882);
    // R2: 0xFF+1 at 8 bits with high garbage: carry and zero
    apply(4'd0, 2'd0, 64'hABCD_00FF, 64'h1234_0001, 0, 0, 0, 4'd2);
    chk("R2", "FF+1 word", {48'd0, flags}, 64'h0047);
    // R12: negative immediate at 64 bits vs 32 bits
    apply(4'd0, 2'd3, 64'd0, 64'd0, 32'hFFFF_FFFF, 1, 0, 4'd8);
    chk("R12", "imm sext 64", result, 64'hFFFF_FFFF_FFFF_FFFF);
    apply(4'd0, 2'd2, 64'd0, 64'd0, 32'hFFFF_FFFF, 1, 0, 4'd8);
    chk("R12", "imm 32", result, 64'h0000_0000_FFFF_FFFF);
    // R7: compare equal values, no write-back, condition E taken
    apply(4'd4, 2'd1, 64'h1234, 64'h1234, 0, 0, 0, 4'd4);
    chk("R7", "cmp wr_en low", {63'd0, wr_en}, 64'd0);
    chk("R11", "cmp equal taken", {63'd0, taken}, 64'd1);
    // R13: undefined code
    apply(4'd12, 2'd3, '1, '1, 0, 0, 1, 4'd10);
    chk("R13", "undef word", {48'd0, flags}, 64'h0002);

    // every condition over signed/unsigned boundary compares
    for (int cc = 0; cc < 16; cc++) begin
      for (int w = 0; w < 4; w++) begin
        apply(4'd4, 2'(w), 64'h80, 64'h7F, 0, 0, 0, 4'(cc));
        apply(4'd4, 2'(w), 64'd5, 64'd5, 0, 0, 0, 4'(cc));
        apply(4'd4, 2'(w), '1, 64'd1, 0, 0, 0, 4'(cc));
        apply(4'd2, 2'(w), 64'd1, 64'd2, 0, 0, 0, 4'(cc));
      end
    end

    // mixed patterns over all operations, widths and conditions
    for (int i = 0; i < 3000; i++) begin
      apply(4'($urandom % 16), 2'($urandom % 4), pick(), pick(),
            $urandom, 1'($urandom % 4 == 0), 1'($urandom), 4'($urandom));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule